// File: doc/BRIEF.md
# Down-Counting Interrupt Timer

This block counts down from a loaded value and raises a timer interrupt request when the count runs out. Software-facing state consists of four pieces of register data: an initial count, the live current count, a divide setting and a vector-table entry. The vector-table entry holds the interrupt vector, a mask flag and a one-shot/periodic mode flag. Registers are loaded through a simple write port that carries a select code and 32 bits of data.

Time is not counted on every clock. Instead, a separate update strobe delivers a batch of elapsed input cycles. The block shifts that batch right by an amount chosen by the divide setting and takes the resulting ticks off the current count. When the ticks reach or pass the remaining count, the count is held at zero. In periodic mode it is instead reloaded from the initial count. Either way, a one-cycle interrupt pulse carrying the vector is emitted unless the entry is masked.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the current count is 0, the divide register reads 0x00000000, the vector-table entry reads 0x00010000 (masked, one-shot, vector 0) and no interrupt pulse is present.
- R2: A write with select 0 stores the data as the initial count and loads the same value into the current count, visible in the cycle after the write edge. Select 1 writes the divide register and select 2 writes the vector-table entry. Select 3 changes no readable state.
- R3: An update has no effect (count unchanged, no pulse) while the initial count is 0, or while the mode is one-shot and the current count is 0.
- R4: Ticks equal the elapsed cycles shifted right by an amount taken from divide bits {3,1,0}. Codes 000 to 110 give shifts 1 to 7, and code 111 gives shift 0. Divide bit 2 has no effect.
- R5: When the ticks are fewer than the current count, the ticks are subtracted from it.
- R6: When the ticks are equal to or greater than the current count, the timer expires. In one-shot mode (entry bit 17 = 0) the count becomes 0.
- R7: On expiry in periodic mode (entry bit 17 = 1) the current count is reloaded from the initial count.
- R8: When entry bit 16 (mask) is 1, expiry produces no interrupt pulse, but the count still expires or reloads.
- R9: The interrupt output is a single-cycle pulse in the cycle after the expiring update edge. It carries entry bits 7:0 as the vector.
- R10: If any of divide bits 31:4 is 1, the divide setting is invalid. An update then leaves the count unchanged and raises no pulse.
- R11: When an initial-count write and an update arrive in the same cycle, the write takes effect and the update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 initial count, 1 divide, 2 vector entry, 3 none |
| wr_data | input | 32 | Write data |
| upd_valid | input | 1 | Update strobe |
| upd_cycles | input | CYC_W | Elapsed input cycles for this update |
| cur_count | output | 32 | Current count |
| div_value | output | 32 | Divide register contents |
| entry_value | output | 32 | Vector-table entry contents |
| irq_valid | output | 1 | One-cycle interrupt pulse |
| irq_vector | output | 8 | Vector carried with the pulse |

## Verification
A corrupted current count shows at `cur_count` in the cycle after the next update or write. Because expiry compares ticks against that count, the same fault also moves the cycle in which `irq_valid` pulses. A wrong shift decode or a misread mode flag appears one cycle after the first update that uses it, as a count that is off by a computable amount or as a missing reload. A wrong mask decode or vector routing appears on the pulse itself, in the cycle after the expiring update.

// File: rtl/tmr_pkg.sv
// Package: shared constants for the down-counting timer.
// Assumes 32-bit registers; field positions are part of the register contract.
package tmr_pkg;
    localparam int REG_W      = 32;
    localparam int VEC_W      = 8;
    localparam int MASK_BIT   = 16;
    localparam int MODE_BIT   = 17;
    localparam int SHIFT_W    = 3;
    localparam int MAX_SHIFT  = 7;
    localparam logic [REG_W-1:0] ENTRY_RESET = 32'h0001_0000;
    localparam logic [REG_W-1:0] DIV_RESET   = 32'h0000_0000;

    typedef enum logic [1:0] {
        SEL_INIT  = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_ENTRY = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_div_decode.sv
// Module: tmr_div_decode
// Turns the divide register into a right-shift amount and a validity flag.
// Assumes bits {3,1,0} carry the code, bit 2 is don't-care, bits 31:4 must be 0.
module tmr_div_decode
    import tmr_pkg::*;
(
    input  logic [REG_W-1:0]   div_reg,
    output logic [SHIFT_W-1:0] shift,
    output logic               div_ok
);
    logic [2:0] code;

    // Gather the code bits and map them to a shift amount.
    always_comb begin
        code   = {div_reg[3], div_reg[1], div_reg[0]};
        shift  = (code == 3'b111) ? 3'd0 : code + 3'd1;
        div_ok = (div_reg[REG_W-1:4] == '0);
    end
endmodule

// File: rtl/tmr_scale.sv
// Module: tmr_scale
// Right-shifts the elapsed cycle batch by the selected amount.
// Assumes shift is in 0..MAX_SHIFT; one candidate per shift amount.
module tmr_scale
    import tmr_pkg::*;
#(
    parameter int CYC_W = 32
)(
    input  logic [CYC_W-1:0]   cycles,
    input  logic [SHIFT_W-1:0] shift,
    output logic [CYC_W-1:0]   ticks
);
    localparam int N_CAND = MAX_SHIFT + 1;
    logic [CYC_W-1:0] cand [N_CAND];

    for (genvar s = 0; s < N_CAND; s++) begin : g_cand
        assign cand[s] = cycles >> s;
    end

    // Select the candidate matching the requested shift.
    always_comb begin
        ticks = cand[0];
        for (int s = 1; s < N_CAND; s++) begin
            if (shift == SHIFT_W'(s)) ticks = cand[s];
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
// Module: tmr_count_core
// Holds the current count, applies ticks, detects expiry, reloads in
// periodic mode and drives the single-cycle interrupt pulse.
// Assumes step_en already includes a valid divide setting; a load wins over a step.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CYC_W = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [REG_W-1:0] load_val,
    input  logic [REG_W-1:0] init_val,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    input  logic             step_en,
    input  logic [CYC_W-1:0] ticks,
    output logic [REG_W-1:0] cur,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    localparam int CMP_W = (CYC_W > REG_W) ? CYC_W : REG_W;

    logic             active;
    logic             expire;
    logic [CMP_W-1:0] tick_x;
    logic [CMP_W-1:0] cur_x;

    // Decide whether this update can act and whether it expires the count.
    always_comb begin
        tick_x = CMP_W'(ticks);
        cur_x  = CMP_W'(cur);
        active = (init_val != '0) && !(!periodic && cur == '0);
        expire = step_en && active && !load_en && !(tick_x < cur_x);
    end

    // Update the current count: load, subtract, clear or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load_en) begin
            cur <= load_val;
        end else if (step_en && active) begin
            if (tick_x < cur_x) cur <= cur - REG_W'(ticks);
            else                cur <= periodic ? init_val : '0;
        end
    end

    // Emit a one-cycle pulse with the vector on an unmasked expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid  <= expire && !masked;
            irq_vector <= (expire && !masked) ? vector : irq_vector;
        end
    end

    // Marks cycles where $past reaches only post-reset values.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r8_mask_blocks_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_valid) |-> !$past(masked));

    a_r9_vector_follows_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_valid) |-> (irq_vector == $past(vector)));

    a_r3_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(init_val) == '0) |-> !irq_valid);

    a_r5_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(load_en) && !($past(periodic) && $past(step_en)))
            |-> (cur <= $past(cur)));

    a_r6_oneshot_lands_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_valid && !$past(periodic)) |-> (cur == '0));
endmodule

// File: rtl/tick_down_timer.sv
// Module: tick_down_timer
// Top of the down-counting interrupt timer: holds the initial count, divide
// and vector-entry registers and wires the decode, scale and count stages.
// Assumes writes and updates are single-cycle strobes in the clk domain.
module tick_down_timer
    import tmr_pkg::*;
#(
    parameter int CYC_W = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             upd_valid,
    input  logic [CYC_W-1:0] upd_cycles,
    output logic [31:0]      cur_count,
    output logic [31:0]      div_value,
    output logic [31:0]      entry_value,
    output logic             irq_valid,
    output logic [7:0]       irq_vector
);
    logic [REG_W-1:0]   init_reg;
    logic [REG_W-1:0]   div_reg;
    logic [REG_W-1:0]   entry_reg;
    logic [SHIFT_W-1:0] shift;
    logic               div_ok;
    logic [CYC_W-1:0]   ticks;
    logic               load_init;
    reg_sel_e           sel;

    // Classify the incoming write.
    always_comb begin
        sel       = reg_sel_e'(wr_sel);
        load_init = wr_en && (sel == SEL_INIT);
    end

    // Configuration registers written through the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_reg  <= '0;
            div_reg   <= DIV_RESET;
            entry_reg <= ENTRY_RESET;
        end else if (wr_en) begin
            case (sel)
                SEL_INIT:  init_reg  <= wr_data;
                SEL_DIV:   div_reg   <= wr_data;
                SEL_ENTRY: entry_reg <= wr_data;
                default:   ;
            endcase
        end
    end

    tmr_div_decode u_dec (
        .div_reg (div_reg),
        .shift   (shift),
        .div_ok  (div_ok)
    );

    tmr_scale #(.CYC_W(CYC_W)) u_scale (
        .cycles (upd_cycles),
        .shift  (shift),
        .ticks  (ticks)
    );

    tmr_count_core #(.CYC_W(CYC_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_init),
        .load_val   (wr_data),
        .init_val   (init_reg),
        .periodic   (entry_reg[MODE_BIT]),
        .masked     (entry_reg[MASK_BIT]),
        .vector     (entry_reg[VEC_W-1:0]),
        .step_en    (upd_valid && div_ok),
        .ticks      (ticks),
        .cur        (cur_count),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    assign div_value   = div_reg;
    assign entry_value = entry_reg;

    a_r10_bad_div_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !wr_en && div_reg[REG_W-1:4] != '0) |=> (!irq_valid && $stable(cur_count)));
endmodule

// File: tb/tick_down_timer_test.sv
module tick_down_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        upd_valid;
    logic [31:0] upd_cycles;
    logic [31:0] cur_count, div_value, entry_value;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    tick_down_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .upd_valid(upd_valid), .upd_cycles(upd_cycles), .cur_count(cur_count),
        .div_value(div_value), .entry_value(entry_value),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Commit one write; outputs are sampled at the following falling edge.
    task automatic do_write(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_update(input logic [31:0] cyc);
        upd_valid = 1'b1; upd_cycles = cyc;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "count", cur_count, 32'd0);
        check("R1", "div", div_value, 32'h0);
        check("R1", "entry", entry_value, 32'h0001_0000);
        check("R1", "irq", {31'd0, irq_valid}, 32'd0);
    endtask

    task automatic t_divider();
        do_write(2'd2, 32'h0000_0040);
        do_write(2'd0, 32'd1000);
        check("R2", "load", cur_count, 32'd1000);
        do_update(32'd100);
        check("R4", "shift1", cur_count, 32'd950);
        check("R5", "no pulse", {31'd0, irq_valid}, 32'd0);
        do_write(2'd1, 32'h4);
        do_update(32'd100);
        check("R4", "bit2 ignored", cur_count, 32'd900);
        do_write(2'd1, 32'hB);
        do_update(32'd100);
        check("R4", "code111 shift0", cur_count, 32'd800);
        do_write(2'd1, 32'h8);
        do_update(32'd3200);
        check("R4", "code100 shift5", cur_count, 32'd700);
        do_write(2'd1, 32'hA);
        do_update(32'd1280);
        check("R4", "code110 shift7", cur_count, 32'd690);
        do_write(2'd1, 32'h3);
        do_update(32'd160);
        check("R4", "code011 shift4", cur_count, 32'd680);
    endtask

    task automatic t_oneshot();
        do_write(2'd1, 32'hB);
        do_update(32'd680);
        check("R6", "oneshot zero", cur_count, 32'd0);
        check("R9", "pulse", {31'd0, irq_valid}, 32'd1);
        check("R9", "vector", {24'd0, irq_vector}, 32'h40);
        @(negedge clk);
        check("R9", "single cycle", {31'd0, irq_valid}, 32'd0);
        do_update(32'd5);
        check("R3", "oneshot idle count", cur_count, 32'd0);
        check("R3", "oneshot idle irq", {31'd0, irq_valid}, 32'd0);
    endtask

    task automatic t_periodic();
        do_write(2'd2, 32'h0002_0055);
        do_write(2'd0, 32'd50);
        do_update(32'd30);
        check("R5", "subtract", cur_count, 32'd20);
        do_update(32'd25);
        check("R7", "reload", cur_count, 32'd50);
        check("R9", "periodic pulse", {31'd0, irq_valid}, 32'd1);
        check("R9", "periodic vector", {24'd0, irq_vector}, 32'h55);
        do_update(32'd10);
        check("R7", "after reload", cur_count, 32'd40);
    endtask

    task automatic t_mask();
        do_write(2'd2, 32'h0003_0055);
        do_update(32'd100);
        check("R8", "masked reload", cur_count, 32'd50);
        check("R8", "masked no pulse", {31'd0, irq_valid}, 32'd0);
    endtask

    task automatic t_zero_init();
        do_write(2'd2, 32'h0002_0011);
        do_write(2'd0, 32'd0);
        do_update(32'd1000);
        check("R3", "init zero count", cur_count, 32'd0);
        check("R3", "init zero irq", {31'd0, irq_valid}, 32'd0);
    endtask

    task automatic t_bad_div();
        do_write(2'd0, 32'd300);
        do_write(2'd1, 32'h1B);
        check("R10", "div readback", div_value, 32'h1B);
        do_update(32'd100);
        check("R10", "frozen count", cur_count, 32'd300);
        do_update(32'd5000);
        check("R10", "no pulse", {31'd0, irq_valid}, 32'd0);
    endtask

    task automatic t_collide();
        do_write(2'd1, 32'hB);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'd77;
        upd_valid = 1'b1; upd_cycles = 32'd1000;
        @(negedge clk);
        wr_en = 1'b0; upd_valid = 1'b0;
        check("R11", "write wins", cur_count, 32'd77);
        check("R11", "no pulse", {31'd0, irq_valid}, 32'd0);
    endtask

    task automatic t_sel_none();
        do_write(2'd3, 32'hFFFF_FFFF);
        check("R2", "sel3 count", cur_count, 32'd77);
        check("R2", "sel3 div", div_value, 32'hB);
        check("R2", "sel3 entry", entry_value, 32'h0002_0011);
        do_update(32'd7);
        check("R2", "sel3 init kept", cur_count, 32'd70);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
        upd_valid = 1'b0; upd_cycles = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divider();
        t_oneshot();
        t_periodic();
        t_mask();
        t_zero_init();
        t_bad_div();
        t_collide();
        t_sel_none();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule